// File: doc/BRIEF.md
# Mode-Selected Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit of configurable width. It takes two operands, a three-bit operation select and a carry input. It returns a result word and a carry output. The top select bit picks the family of the operation. When that bit is 0, the operation is arithmetic. A chain of full-adder stages adds the first operand to a second adder input, and that second input is chosen by the two low select bits from four values: zero, the second operand, its bitwise complement, or all ones. The carry input enters the lowest stage. Increment, add, add-with-carry, subtract, subtract-with-borrow, decrement and pass-through all come from these choices.

When the top select bit is 1, the same two low select bits choose a bitwise logic function. In that mode the adder's carry has no effect on the outputs, and the carry output is held at 0. The block holds no state, so its outputs follow its inputs within the same cycle. It is meant to be placed between registers that an enclosing datapath owns.

Top module: `msalu`

## Requirements
- R1: Select 3'b000 gives result = op_a + carry_in (op_a when carry_in is 0, op_a+1 when it is 1). carry_out is the carry out of that sum.
- R2: Select 3'b001 gives result = op_a + op_b + carry_in, modulo 2^WIDTH. carry_out is bit WIDTH of the full sum.
- R3: Select 3'b010 gives result = op_a + ~op_b + carry_in: op_a-op_b-1 when carry_in is 0, op_a-op_b when it is 1. carry_out is bit WIDTH of that sum, so it is 1 when no borrow occurs.
- R4: Select 3'b011 gives result = op_a + all-ones + carry_in: op_a-1 when carry_in is 0, op_a when it is 1. carry_out is bit WIDTH of that sum.
- R5: Select 3'b100 gives result = op_a OR op_b, and select 3'b101 gives result = op_a XOR op_b.
- R6: Select 3'b110 gives result = op_a AND op_b, and select 3'b111 gives result = the bitwise complement of op_a.
- R7: With sel[2] = 1, carry_in has no effect on result, and carry_out is 0.
- R8: The carry ripples through every stage. With op_a all ones, select 3'b000 and carry_in 1, result is 0 and carry_out is 1. The same inputs with carry_in 0 give result all ones and carry_out 0.
- R9: The block is combinational. A change on any input is visible on result and carry_out in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand, always the adder's direct input |
| op_b | input | WIDTH | Second operand |
| sel | input | 3 | Operation select. Bit 2 = family (0 arithmetic, 1 logic). Bits 1:0 = function within the family |
| carry_in | input | 1 | Carry into the lowest adder stage |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry from the top adder stage in arithmetic modes, 0 in logic modes |

## Verification
A wrong choice of the second adder input shows up immediately at the result port as a fixed offset. For example, a swapped complement turns a subtraction into an addition for every operand pair of that select. A broken carry link between two stages corrupts only those operand pairs whose carry has to cross that stage. For this reason, the sweep over every operand pair, every select and both carry values includes the all-ones operand with a carry in. A carry leaking into a logic mode appears on carry_out at once.

// File: rtl/msalu_pkg.sv
package msalu_pkg;

   // Second adder input chosen by sel[1:0] in arithmetic family
   typedef enum logic [1:0] {
      YSRC_ZERO = 2'b00,
      YSRC_B    = 2'b01,
      YSRC_BINV = 2'b10,
      YSRC_ONES = 2'b11
   } ysrc_e;

   // Bitwise function chosen by sel[1:0] in logic family
   typedef enum logic [1:0] {
      LFN_OR   = 2'b00,
      LFN_XOR  = 2'b01,
      LFN_AND  = 2'b10,
      LFN_NOTA = 2'b11
   } lfn_e;

   // Implementation variants of the logic slice
   localparam int unsigned LOGIC_IMPL_MUX   = 0;
   localparam int unsigned LOGIC_IMPL_GATED = 1;

   function automatic ysrc_e to_ysrc(input logic [1:0] code);
      return ysrc_e'(code);
   endfunction

   function automatic lfn_e to_lfn(input logic [1:0] code);
      return lfn_e'(code);
   endfunction

endpackage

// File: rtl/msalu_fa.sv
module msalu_fa (
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);

   logic half_sum;

   always_comb begin
      half_sum = x_i ^ y_i;
      s_o      = half_sum ^ c_i;
      c_o      = (x_i & y_i) | (half_sum & c_i);
   end

endmodule

// File: rtl/msalu_arith.sv
module msalu_arith
   import msalu_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       ysel_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   localparam int unsigned NCARRY = WIDTH + 1;

   ysrc_e            ysrc;
   logic [WIDTH-1:0] y_vec;
   logic [NCARRY-1:0] chain;

   assign ysrc     = to_ysrc(ysel_i);
   assign chain[0] = cin_i;

   for (genvar k = 0; k < WIDTH; k++) begin : g_stage
      logic y_bit;

      always_comb begin
         unique case (ysrc)
            YSRC_ZERO: y_bit = 1'b0;
            YSRC_B:    y_bit = b_i[k];
            YSRC_BINV: y_bit = ~b_i[k];
            YSRC_ONES: y_bit = 1'b1;
            default:   y_bit = 1'b0;
         endcase
      end

      assign y_vec[k] = y_bit;

      msalu_fa u_fa (
         .x_i (a_i[k]),
         .y_i (y_vec[k]),
         .c_i (chain[k]),
         .s_o (sum_o[k]),
         .c_o (chain[k+1])
      );
   end

   assign cout_o = chain[WIDTH];

endmodule

// File: rtl/msalu_logic.sv
module msalu_logic
   import msalu_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned IMPL  = LOGIC_IMPL_MUX
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       fsel_i,
   output logic [WIDTH-1:0] res_o
);

   lfn_e fn;
   assign fn = to_lfn(fsel_i);

   if (IMPL == LOGIC_IMPL_MUX) begin : g_mux
      // per-bit four-way selector of precomputed functions
      for (genvar k = 0; k < WIDTH; k++) begin : g_bit
         logic [3:0] cand;
         assign cand[LFN_OR]   = a_i[k] | b_i[k];
         assign cand[LFN_XOR]  = a_i[k] ^ b_i[k];
         assign cand[LFN_AND]  = a_i[k] & b_i[k];
         assign cand[LFN_NOTA] = ~a_i[k];
         assign res_o[k] = cand[fsel_i];
      end
   end else begin : g_gated
      // decoded enables gate each term onto an OR
      logic en_or, en_xor, en_and, en_not;
      always_comb begin
         en_or  = (fn == LFN_OR);
         en_xor = (fn == LFN_XOR);
         en_and = (fn == LFN_AND);
         en_not = (fn == LFN_NOTA);
      end
      for (genvar k = 0; k < WIDTH; k++) begin : g_bit
         assign res_o[k] = (en_or  & (a_i[k] | b_i[k]))
                         | (en_xor & (a_i[k] ^ b_i[k]))
                         | (en_and & (a_i[k] & b_i[k]))
                         | (en_not & ~a_i[k]);
      end
   end

endmodule

// File: rtl/msalu.sv
module msalu
   import msalu_pkg::*;
#(
   parameter int unsigned WIDTH      = 4,
   parameter int unsigned LOGIC_IMPL = LOGIC_IMPL_MUX
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [2:0]       sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("msalu: WIDTH must be at least 1");
   end
   if (LOGIC_IMPL > LOGIC_IMPL_GATED) begin : g_bad_impl
      $error("msalu: LOGIC_IMPL must be 0 or 1");
   end

   logic             fam_logic;
   logic [WIDTH-1:0] arith_sum;
   logic             arith_cout;
   logic [WIDTH-1:0] logic_res;

   assign fam_logic = sel[2];

   msalu_arith #(.WIDTH(WIDTH)) u_arith (
      .a_i    (op_a),
      .b_i    (op_b),
      .ysel_i (sel[1:0]),
      .cin_i  (carry_in),
      .sum_o  (arith_sum),
      .cout_o (arith_cout)
   );

   msalu_logic #(.WIDTH(WIDTH), .IMPL(LOGIC_IMPL)) u_logic (
      .a_i    (op_a),
      .b_i    (op_b),
      .fsel_i (sel[1:0]),
      .res_o  (logic_res)
   );

   always_comb begin
      if (fam_logic) begin
         result    = logic_res;
         carry_out = 1'b0;
      end else begin
         result    = arith_sum;
         carry_out = arith_cout;
      end
   end

endmodule

// File: rtl/msalu_chk.sv
module msalu_chk #(
   parameter int unsigned WIDTH = 4
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [2:0]       sel,
   input logic             carry_in,
   input logic [WIDTH-1:0] result,
   input logic             carry_out
);

   logic [WIDTH:0] ref_sum;

   always_comb begin
      ref_sum = '0;
      if (!$isunknown({op_a, op_b, sel, carry_in, result, carry_out})) begin
         // R7
         logic_cout_chk: assert (!(sel[2] && carry_out));
         // R5
         or_res_chk: assert (sel != 3'b100 || result == (op_a | op_b));
         // R5
         xor_res_chk: assert (sel != 3'b101 || result == (op_a ^ op_b));
         // R6
         and_res_chk: assert (sel != 3'b110 || result == (op_a & op_b));
         // R6
         nota_res_chk: assert (sel != 3'b111 || result == ~op_a);
         // R2
         ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
         add_sum_chk: assert (sel != 3'b001 || {carry_out, result} == ref_sum);
         // R3
         ref_sum = {1'b0, op_a} - {1'b0, op_b} - {{WIDTH{1'b0}}, ~carry_in}
                   + {1'b1, {WIDTH{1'b0}}};
         sub_sum_chk: assert (sel != 3'b010 || {carry_out, result} == ref_sum);
      end
   end

endmodule

bind msalu msalu_chk #(.WIDTH(WIDTH)) u_msalu_chk (
   .op_a      (op_a),
   .op_b      (op_b),
   .sel       (sel),
   .carry_in  (carry_in),
   .result    (result),
   .carry_out (carry_out)
);

// File: tb/msalu_tb_top.sv
module msalu_tb_top;

   localparam int W = 4;
   localparam int MASK = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [W-1:0] op_a, op_b, result;
   logic [2:0]   sel;
   logic         carry_in, carry_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   msalu #(.WIDTH(W)) dut_i (
      .op_a(op_a), .op_b(op_b), .sel(sel), .carry_in(carry_in),
      .result(result), .carry_out(carry_out)
   );

   // vector fields: sel[3], cin[1], a[4], b[4], exp_f[4], exp_c[1]
   localparam int NV = 16;
   localparam logic [16:0] VEC [NV] = '{
      {3'b000, 1'b0, 4'h5, 4'h9, 4'h5, 1'b0},  // R1 pass
      {3'b000, 1'b1, 4'h5, 4'h9, 4'h6, 1'b0},  // R1 increment
      {3'b001, 1'b0, 4'h7, 4'h8, 4'hF, 1'b0},  // R2 add
      {3'b001, 1'b1, 4'h9, 4'h9, 4'h3, 1'b1},  // R2 add+1 overflow
      {3'b010, 1'b1, 4'h9, 4'h3, 4'h6, 1'b1},  // R3 subtract
      {3'b010, 1'b0, 4'h9, 4'h3, 4'h5, 1'b1},  // R3 subtract with borrow
      {3'b010, 1'b1, 4'h2, 4'h5, 4'hD, 1'b0},  // R3 negative result
      {3'b011, 1'b0, 4'h0, 4'h4, 4'hF, 1'b0},  // R4 decrement zero
      {3'b011, 1'b0, 4'h8, 4'h4, 4'h7, 1'b1},  // R4 decrement
      {3'b011, 1'b1, 4'hA, 4'h4, 4'hA, 1'b1},  // R4 pass
      {3'b100, 1'b1, 4'hA, 4'h5, 4'hF, 1'b0},  // R5 or, R7
      {3'b101, 1'b0, 4'hC, 4'hA, 4'h6, 1'b0},  // R5 xor
      {3'b110, 1'b1, 4'hC, 4'hA, 4'h8, 1'b0},  // R6 and, R7
      {3'b111, 1'b1, 4'h3, 4'hF, 4'hC, 1'b0},  // R6 not a, R7
      {3'b000, 1'b1, 4'hF, 4'h0, 4'h0, 1'b1},  // R8 full ripple
      {3'b000, 1'b0, 4'hF, 4'h0, 4'hF, 1'b0}   // R8 no carry
   };

   task automatic check(input string req, input logic [W-1:0] ef, input logic ec);
      checks++;
      if (result !== ef || carry_out !== ec) begin
         failures++;
         $display("FAIL %s sel=%b cin=%b a=%h b=%h: got f=%h c=%b expected f=%h c=%b",
                  req, sel, carry_in, op_a, op_b, result, carry_out, ef, ec);
      end
   endtask

   function automatic void ref_model(input int s, input int ci, input int a, input int b,
                                     output logic [W-1:0] f, output logic c);
      int sum;
      sum = 0;
      case (s)
         0: sum = a + ci;
         1: sum = a + b + ci;
         2: sum = a + (MASK - b) + ci;
         3: sum = a + MASK + ci;
         4: sum = a | b;
         5: sum = a ^ b;
         6: sum = a & b;
         default: sum = (~a) & MASK;
      endcase
      f = sum[W-1:0];
      c = (s < 4) ? sum[W] : 1'b0;
   endfunction

   initial begin
      #200000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] ef;
      logic ec;
      op_a = '0; op_b = '0; sel = '0; carry_in = 1'b0;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle state", 4'h0, 1'b0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(posedge clk);
         {sel, carry_in, op_a, op_b} = VEC[i][16:5];
         @(negedge clk);
         check("R1-table", VEC[i][4:1], VEC[i][0]);
      end

      // exhaustive sweep against the model
      for (int s = 0; s < 8; s++)
         for (int ci = 0; ci < 2; ci++)
            for (int a = 0; a <= MASK; a++)
               for (int b = 0; b <= MASK; b++) begin
                  @(posedge clk);
                  sel = 3'(s); carry_in = ci[0]; op_a = W'(a); op_b = W'(b);
                  @(negedge clk);
                  ref_model(s, ci, a, b, ef, ec);
                  case (s)
                     0: check("R1", ef, ec);
                     1: check("R2", ef, ec);
                     2: check("R3", ef, ec);
                     3: check("R4", ef, ec);
                     4, 5: check("R5", ef, ec);
                     default: check("R6", ef, ec);
                  endcase
               end

      // R7: toggling carry_in in logic family leaves outputs unchanged
      for (int s = 4; s < 8; s++) begin
         @(posedge clk);
         sel = 3'(s); op_a = 4'h9; op_b = 4'h6; carry_in = 1'b0;
         @(negedge clk);
         ref_model(s, 0, 9, 6, ef, ec);
         check("R7 cin=0", ef, 1'b0);
         carry_in = 1'b1;
         #1;
         check("R7 cin=1", ef, 1'b0);
      end

      // R9: outputs respond between edges without a clock
      @(negedge clk);
      sel = 3'b001; carry_in = 1'b0; op_a = 4'h3; op_b = 4'h4;
      #1;
      check("R9 comb add", 4'h7, 1'b0);
      carry_in = 1'b1;
      #1;
      check("R9 comb cin", 4'h8, 1'b0);

      // R8: ripple end to end
      sel = 3'b000; op_a = 4'hF; carry_in = 1'b1;
      #1;
      check("R8 ripple", 4'h0, 1'b1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule